// File: doc/BRIEF.md
# Per-Lane PC Reconvergence Arbiter

This block schedules a group of lanes that share one instruction fetch path. No divergence stack is shared between them. Each lane keeps its own program counter and its own call-depth pointer. Every cycle the block chooses one master PC for fetch. The choice is the smallest key formed by placing the depth pointer above the PC and comparing the result as one unsigned number. Lanes whose PC equals the master execute the fetched instruction. All other lanes ignore it.

At the end of a cycle in which a lane is active, the datapath returns a control code and a target for that lane. The lane then steps to the next address, jumps, calls or returns, and the block chooses the next master. A call moves the depth pointer down, so lanes inside a callee are served before lanes still waiting in the caller. Lanes that split at an if/else come back together without any extra instruction: then-code lies below else-code, and both lie below the join point. A lane with its done flag raised drops out of the choice.

Top module: `lane_pc_arbiter`

## Requirements
- R1: While rst_ni is low, valid_o is 0, active_o is all zeros and master_pc_o is 0.
- R2: After reset is released, every lane holds PC ENTRY_PC (default 0) and depth all ones. On the first clock edge the outputs become valid_o=1 and master_pc_o=ENTRY_PC, with every lane that is not done active.
- R3: Among the lanes that are not done, master_pc_o is the PC field of the smallest key {depth, PC}, compared as one unsigned value. A lower depth wins, and a lower PC breaks a tie.
- R4: A lane is set in active_o exactly when it is not done and its PC equals master_pc_o. While valid_o is 1, at least one lane is active.
- R5: The 2-bit code op_i[2l+1:2l] of an active lane is applied at the clock edge that ends the cycle. Code 0 sets the lane's PC to master_pc_o+1. Code 1 sets it to target_i[l*PC_W +: PC_W].
- R6: Code 2 (call) sets the PC to the target and decrements the depth by one. Code 3 (return) sets the PC to the target and increments the depth by one.
- R7: A lane that is not active, or that is active while valid_o is 0, keeps its PC and depth unchanged.
- R8: Lanes whose done_i bit is 1 at an edge are left out of that edge's selection. When all lanes are done, valid_o goes to 0 and active_o goes to all zeros.
- R9: Lanes that split on a forward branch and later reach a common higher address become active together again at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | LANES | Per-lane done flag; a lane with this flag set is left out of the selection |
| op_i | input | 2*LANES | Per-lane control code: 0 fall-through, 1 jump, 2 call, 3 return |
| target_i | input | PC_W*LANES | Per-lane branch, call or return target |
| master_pc_o | output | PC_W | Master PC to fetch |
| active_o | output | LANES | Lanes whose PC matches the master |
| valid_o | output | 1 | At least one lane is not done |

## Verification
Two functions can fall on the same edge. A call or return can change a lane's depth while a done flag changes which lanes take part in the selection. A depth change can also make a lane win at a higher PC than a lane that is waiting at a lower PC. The directed part of the bench provokes both cases. It calls into a target above the waiting lanes and checks that only the callee lane is active. It then raises done on half the lanes in the same cycle that the others step forward. The random part of the bench mixes calls, returns, jumps and done flags on every edge. Each cycle it compares the master and the mask against a behavioural per-lane model.

// File: rtl/pcarb_pkg.sv
package pcarb_pkg;
  typedef enum logic [1:0] {
    OP_SEQ  = 2'd0,
    OP_JUMP = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } ctl_op_e;
endpackage

// File: rtl/pcarb_lane.sv
module pcarb_lane
  import pcarb_pkg::*;
#(
  parameter int unsigned PC_W = 16,
  parameter int unsigned SP_W = 16,
  parameter logic [PC_W-1:0] ENTRY_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  ctl_op_e         op_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o,
  output logic [SP_W-1:0] sp_o,
  output logic [PC_W-1:0] pc_n_o,
  output logic [SP_W-1:0] sp_n_o
);

  always_comb begin
    pc_n_o = pc_o;
    sp_n_o = sp_o;
    if (en_i) begin
      unique case (op_i)
        OP_SEQ:  pc_n_o = pc_o + PC_W'(1);
        OP_JUMP: pc_n_o = target_i;
        OP_CALL: begin
          pc_n_o = target_i;
          sp_n_o = sp_o - SP_W'(1);
        end
        OP_RET: begin
          pc_n_o = target_i;
          sp_n_o = sp_o + SP_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o <= ENTRY_PC;
      sp_o <= '1;
    end else begin
      pc_o <= pc_n_o;
      sp_o <= sp_n_o;
    end
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(pc_o) && $stable(sp_o)));

  p_call_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_CALL) |=> (sp_o == $past(sp_o) - SP_W'(1)));

  p_ret_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_RET) |=> (sp_o == $past(sp_o) + SP_W'(1)));

  p_seq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == OP_SEQ) |=> (pc_o == $past(pc_o) + PC_W'(1)));

endmodule

// File: rtl/pcarb_min_tree.sv
module pcarb_min_tree #(
  parameter int unsigned N     = 4,
  parameter int unsigned KEY_W = 32
) (
  input  logic [N*KEY_W-1:0] keys_i,
  input  logic [N-1:0]       vld_i,
  output logic [KEY_W-1:0]   key_o,
  output logic               vld_o
);

  localparam int unsigned LVL   = (N > 1) ? $clog2(N) : 0;
  localparam int unsigned LEAF  = 1 << LVL;
  localparam int unsigned NODES = 2 * LEAF - 1;

  logic [KEY_W-1:0] node_key [NODES];
  logic             node_vld [NODES];

  for (genvar j = 0; j < LEAF; j++) begin : g_leaf
    if (j < N) begin : g_real
      assign node_key[LEAF-1+j] = keys_i[j*KEY_W +: KEY_W];
      assign node_vld[LEAF-1+j] = vld_i[j];
    end else begin : g_pad
      assign node_key[LEAF-1+j] = '1;
      assign node_vld[LEAF-1+j] = 1'b0;
    end
  end

  for (genvar i = 0; i < LEAF - 1; i++) begin : g_node
    logic take_left;
    assign take_left = node_vld[2*i+1] &&
                       (!node_vld[2*i+2] || node_key[2*i+1] <= node_key[2*i+2]);
    assign node_key[i] = take_left ? node_key[2*i+1] : node_key[2*i+2];
    assign node_vld[i] = node_vld[2*i+1] | node_vld[2*i+2];
  end

  assign key_o = node_key[0];
  assign vld_o = node_vld[0];

endmodule

// File: rtl/lane_pc_arbiter.sv
module lane_pc_arbiter
  import pcarb_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned PC_W  = 16,
  parameter int unsigned SP_W  = 16,
  parameter logic [PC_W-1:0] ENTRY_PC = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [LANES-1:0]      done_i,
  input  logic [2*LANES-1:0]    op_i,
  input  logic [PC_W*LANES-1:0] target_i,
  output logic [PC_W-1:0]       master_pc_o,
  output logic [LANES-1:0]      active_o,
  output logic                  valid_o
);

  localparam int unsigned KEY_W = SP_W + PC_W;

  logic [PC_W-1:0]        lane_pc   [LANES];
  logic [SP_W-1:0]        lane_sp   [LANES];
  logic [PC_W-1:0]        lane_pc_n [LANES];
  logic [SP_W-1:0]        lane_sp_n [LANES];
  logic [LANES*KEY_W-1:0] cand_keys;
  logic [KEY_W-1:0]       root_key;
  logic                   root_vld;
  logic [PC_W-1:0]        root_pc;
  logic [LANES-1:0]       match_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pcarb_lane #(
      .PC_W    (PC_W),
      .SP_W    (SP_W),
      .ENTRY_PC(ENTRY_PC)
    ) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (valid_o & active_o[l]),
      .op_i    (ctl_op_e'(op_i[2*l +: 2])),
      .target_i(target_i[PC_W*l +: PC_W]),
      .pc_o    (lane_pc[l]),
      .sp_o    (lane_sp[l]),
      .pc_n_o  (lane_pc_n[l]),
      .sp_n_o  (lane_sp_n[l])
    );
    assign cand_keys[l*KEY_W +: KEY_W] = {lane_sp_n[l], lane_pc_n[l]};
    assign match_n[l] = root_vld && !done_i[l] && (lane_pc_n[l] == root_pc);

    p_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      active_o[l] |-> (lane_pc[l] == master_pc_o));
  end

  // selection looks at post-update state so outputs never lag the lanes
  pcarb_min_tree #(
    .N    (LANES),
    .KEY_W(KEY_W)
  ) u_min (
    .keys_i(cand_keys),
    .vld_i (~done_i),
    .key_o (root_key),
    .vld_o (root_vld)
  );

  assign root_pc = root_key[PC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      master_pc_o <= '0;
      active_o    <= '0;
    end else begin
      valid_o  <= root_vld;
      active_o <= match_n;
      if (root_vld) master_pc_o <= root_pc;
    end
  end

  p_nonempty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (active_o != '0));

  p_idle_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (active_o == '0));

  p_done_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i == '1) |=> !valid_o);

endmodule

// File: tb/tb_lane_pc_arbiter.sv
module tb_lane_pc_arbiter;
  localparam int LANES = 4;
  localparam int PC_W = 16;
  localparam int SP_W = 16;
  localparam int CLK_PERIOD = 10;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [LANES-1:0]      done_i = '0;
  logic [2*LANES-1:0]    op_i = '0;
  logic [PC_W*LANES-1:0] target_i = '0;
  logic [PC_W-1:0]       master_pc_o;
  logic [LANES-1:0]      active_o;
  logic                  valid_o;

  int total = 0;
  int bad = 0;

  int          m_pc [LANES];
  int          m_sp [LANES];
  int          m_master;
  logic [LANES-1:0] m_active;
  bit          m_valid;

  lane_pc_arbiter #(.LANES(LANES), .PC_W(PC_W), .SP_W(SP_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_i), .op_i(op_i),
    .target_i(target_i), .master_pc_o(master_pc_o), .active_o(active_o),
    .valid_o(valid_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model_eval(input logic [LANES-1:0] dn);
    longint best = -1;
    for (int l = 0; l < LANES; l++) begin
      longint k = (longint'(m_sp[l]) << PC_W) | longint'(m_pc[l]);
      if (!dn[l] && (best < 0 || k < best)) best = k;
    end
    m_valid = (best >= 0);
    if (m_valid) m_master = int'(best & 64'hFFFF);
    for (int l = 0; l < LANES; l++)
      m_active[l] = m_valid && !dn[l] && (m_pc[l] == m_master);
  endfunction

  task automatic compare_all();
    chk(valid_o == m_valid, "R8 valid", valid_o, m_valid);
    if (m_valid) begin
      chk(master_pc_o == m_master[PC_W-1:0], "R3 master", master_pc_o, m_master);
      chk(active_o == m_active, "R4 mask", active_o, m_active);
    end else begin
      chk(active_o == '0, "R8 mask", active_o, 0);
    end
  endtask

  // drive at negedge, model the edge, check at next negedge
  task automatic cyc(input logic [2*LANES-1:0] op, input logic [PC_W*LANES-1:0] tg,
                     input logic [LANES-1:0] dn);
    op_i = op; target_i = tg; done_i = dn;
    for (int l = 0; l < LANES; l++) begin
      if (m_valid && m_active[l]) begin
        int t = int'(tg[l*PC_W +: PC_W]);
        case (op[2*l +: 2])
          2'd0: m_pc[l] = (m_pc[l] + 1) & 16'hFFFF;
          2'd1: m_pc[l] = t;
          2'd2: begin m_pc[l] = t; m_sp[l] = (m_sp[l] - 1) & 16'hFFFF; end
          default: begin m_pc[l] = t; m_sp[l] = (m_sp[l] + 1) & 16'hFFFF; end
        endcase
      end
    end
    model_eval(dn);
    @(posedge clk_i);
    @(negedge clk_i);
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int l = 0; l < LANES; l++) begin m_pc[l] = 0; m_sp[l] = 16'hFFFF; end
    m_valid = 0; m_active = '0; m_master = 0;
    repeat (3) @(negedge clk_i);
    chk(valid_o == 0 && active_o == '0 && master_pc_o == '0, "R1 reset",
        {valid_o, active_o, master_pc_o}, 0);
    rst_ni = 1'b1;
    model_eval('0);
    @(posedge clk_i);
    @(negedge clk_i);
    compare_all();
    chk(valid_o && master_pc_o == 16'd0 && active_o == 4'hF, "R2 entry",
        {valid_o, active_o, master_pc_o}, {1'b1, 4'hF, 16'd0});

    // if/else split: lanes 0,1 jump to 5, lanes 2,3 fall through
    cyc({2'd0, 2'd0, 2'd1, 2'd1}, {4{16'd5}}, '0);
    chk(master_pc_o == 16'd1 && active_o == 4'b1100, "R5 seq/jump",
        {active_o, master_pc_o}, {4'b1100, 16'd1});
    cyc('0, {4{16'd5}}, '0);
    cyc('0, {4{16'd5}}, '0);
    cyc({4{2'd1}}, {4{16'd7}}, '0);
    chk(master_pc_o == 16'd5 && active_o == 4'b0011, "R7 hold",
        {active_o, master_pc_o}, {4'b0011, 16'd5});
    cyc('0, {4{16'd7}}, '0);
    cyc('0, {4{16'd7}}, '0);
    chk(master_pc_o == 16'd7 && active_o == 4'hF, "R9 reconverge",
        {active_o, master_pc_o}, {4'hF, 16'd7});

    // call into a higher address wins over lower-PC caller lanes
    cyc({2'd0, 2'd0, 2'd0, 2'd2}, {4{16'd20}}, '0);
    chk(master_pc_o == 16'd20 && active_o == 4'b0001, "R6 call",
        {active_o, master_pc_o}, {4'b0001, 16'd20});
    cyc({2'd0, 2'd0, 2'd0, 2'd3}, {4{16'd8}}, '0);
    chk(master_pc_o == 16'd8 && active_o == 4'hF, "R6 return",
        {active_o, master_pc_o}, {4'hF, 16'd8});

    // done flags
    cyc('0, '0, 4'b0101);
    chk(master_pc_o == 16'd9 && active_o == 4'b1010, "R8 partial done",
        {active_o, master_pc_o}, {4'b1010, 16'd9});
    cyc('0, '0, 4'hF);
    chk(valid_o == 0 && active_o == '0, "R8 all done", {valid_o, active_o}, 0);
    cyc({4{2'd1}}, {4{16'd3}}, '0);
    chk(master_pc_o == 16'd9 && active_o == 4'b0101, "R7 no update while invalid",
        {active_o, master_pc_o}, {4'b0101, 16'd9});

    // random mix checked against the model
    for (int n = 0; n < 4000; n++) begin
      logic [2*LANES-1:0] op;
      logic [PC_W*LANES-1:0] tg;
      logic [LANES-1:0] dn;
      for (int l = 0; l < LANES; l++) begin
        logic [1:0] o;
        o = 2'($urandom % 4);
        if (o == 2'd3 && m_sp[l] == 16'hFFFF) o = 2'd0;
        if (o == 2'd2 && m_sp[l] == 0) o = 2'd0;
        op[2*l +: 2] = o;
        tg[l*PC_W +: PC_W] = 16'($urandom % 32);
        dn[l] = ($urandom % 8 == 0);
      end
      if (n % 500 == 499) dn = '1;
      cyc(op, tg, dn);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule